// File: doc/BRIEF.md
# Alarm Interrupt Command and Routing Stage

This block holds the command byte that governs how two alarm sources reach the outside world. One source is a time-of-day alarm and the other is a watchdog expiry. Each source has a sticky flag. The alarm logic sets the flag with a one-cycle event, and an access to that source's own alarm registers clears it. Host software cannot write either flag through the command register. The same byte also holds a per-source mask, a choice between level and fixed-width pulse signalling, a drive direction for the second output, a bit that swaps which source lands on which output, and a transfer-enable bit that is passed on to the timekeeping logic.

There are two interrupt outputs, A and B. Each is a pair: a drive-enable and the level driven while it is enabled. This lets one model cover both an open-drain pull-down and an actively sourced high. Output A always pulls low. Output B pulls low or drives high, as the polarity bit selects. In pulse mode, each rising edge of an unmasked flag produces a pulse of `PULSE_CYCLES` clock cycles. The default is 3 ms at 200 MHz.

Top module: `alarm_irq_router`

## Requirements
- R1: After reset the command register reads 0x0C. Both flags (bits 0 and 1) are clear, both masks (bits 2 and 3) are set, bits 4 to 7 are 0, and neither output is driven.
- R2: A `todMatch` pulse sets the time-of-day flag (bit 0) in the next cycle. `todRegRd` clears it. If both arrive in the same cycle, the set wins.
- R3: A `wdExpire` pulse sets the watchdog flag (bit 1) in the next cycle. `wdRegAcc` clears it. If both arrive in the same cycle, the set wins.
- R4: A command write stores bits 7 to 2, which read back on `cmdRdData`, and leaves bits 1 and 0 unchanged. `xferEn` equals bit 7.
- R5: Bit 2 = 1 keeps the time-of-day interrupt off both outputs, and bit 3 = 1 does the same for the watchdog interrupt, whatever the flags hold.
- R6: With bit 4 = 0 (level mode), a source's output is driven exactly while its flag is set and unmasked. The output follows the flag register in the same cycle.
- R7: With bit 4 = 1 (pulse mode), the rising edge of an unmasked flag drives its output for exactly `PULSE_CYCLES` cycles, starting in the cycle the flag first reads set. The output is then released even if the flag stays set.
- R8: Output A drives low (`intALvl` = 0) whenever it is enabled.
- R9: The level on `intBLvl` equals bit 5: 1 means output B sources high, 0 means it sinks low.
- R10: Bit 6 = 1 routes time-of-day to output A and watchdog to output B. Bit 6 = 0 swaps them. A change takes effect in the cycle after the write, even on an active interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Write strobe for the command register |
| cmdWrData | input | 8 | Write data for the command register |
| cmdRdData | output | 8 | Current command register contents |
| todMatch | input | 1 | Time-of-day alarm event (sets flag 0) |
| wdExpire | input | 1 | Watchdog expiry event (sets flag 1) |
| todRegRd | input | 1 | Read of any time-of-day alarm register (clears flag 0) |
| wdRegAcc | input | 1 | Read or write of any watchdog register (clears flag 1) |
| intAEn | output | 1 | Output A drive enable |
| intALvl | output | 1 | Output A driven level |
| intBEn | output | 1 | Output B drive enable |
| intBLvl | output | 1 | Output B driven level |
| xferEn | output | 1 | Transfer-enable bit to the timekeeping logic |

## Verification
A flag that sets or clears late, or at the wrong time, shows on `cmdRdData` one cycle after the event. In level mode it also shows on the routed output in that same cycle. A wrong swap bit or mask bit sends an interrupt to the wrong pin, or silences it, in the first cycle in which a flag is set. A pulse counter that is off by one shows only at the end of a pulse, so the bench counts every pulse cycle by cycle. It compares all outputs against its own model on every clock.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int CMD_W     = 8;
  localparam int NUM_SRC   = 2;
  localparam int SRC_TOD   = 0;
  localparam int SRC_WD    = 1;
  localparam int MASK_BASE = 2;
  localparam int BIT_PULSE = 4;
  localparam int BIT_BPOL  = 5;
  localparam int BIT_ROUTE = 6;
  localparam int BIT_XFER  = 7;
  localparam logic [CMD_W-1:0] CMD_RESET = 8'h0C;
  localparam logic [CMD_W-1:0] FLAG_BITS = 8'h03;

  typedef struct packed {
    logic               wrCmd;
    logic [NUM_SRC-1:0] setFlag;
    logic [NUM_SRC-1:0] clrFlag;
  } strobe_t;
endpackage

// File: rtl/alarm_irq_ctl.sv
module alarm_irq_ctl
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_CYCLES = 600000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic               todMatch,
  input  logic               wdExpire,
  input  logic               todRegRd,
  input  logic               wdRegAcc,
  input  logic [NUM_SRC-1:0] srcAct,
  output strobe_t            stb,
  output logic [NUM_SRC-1:0] pulseOn
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_CYCLES - 1);

  always_comb begin
    stb.wrCmd            = cmdWrEn;
    stb.setFlag[SRC_TOD] = todMatch;
    stb.setFlag[SRC_WD]  = wdExpire;
    stb.clrFlag[SRC_TOD] = todRegRd;
    stb.clrFlag[SRC_WD]  = wdRegAcc;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pulse
    logic             actPrev;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise       = srcAct[i] & ~actPrev;
    assign pulseOn[i] = rise | (cnt != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actPrev <= 1'b0;
        cnt     <= '0;
      end else begin
        actPrev <= srcAct[i];
        if (rise)            cnt <= RELOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
    end

    // R7: a running pulse never outlasts its programmed width
    p_pulse_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cnt != '0) |-> (cnt <= RELOAD));
    // R7: a fresh edge always lights the pulse in the same cycle
    p_pulse_starts_r7: assert property (@(posedge clk) disable iff (!rstN)
      (srcAct[i] && !actPrev) |-> pulseOn[i]);
  end
endmodule

// File: rtl/alarm_irq_dp.sv
module alarm_irq_dp
  import alarm_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [CMD_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] pulseOn,
  output logic [CMD_W-1:0]   cmdQ,
  output logic [NUM_SRC-1:0] srcAct,
  output logic               intAEn,
  output logic               intALvl,
  output logic               intBEn,
  output logic               intBLvl,
  output logic               xferEn
);
  logic [NUM_SRC-1:0] flagQ;
  logic [CMD_W-1:0]   ctrlQ;
  logic [NUM_SRC-1:0] srcOut;
  logic               pulseMode;
  logic               routeTodA;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                flagQ[i] <= 1'b0;
      else if (stb.setFlag[i])  flagQ[i] <= 1'b1;
      else if (stb.clrFlag[i])  flagQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctrlQ <= CMD_RESET & ~FLAG_BITS;
    else if (stb.wrCmd) ctrlQ <= wrData & ~FLAG_BITS;
  end

  assign cmdQ      = (ctrlQ & ~FLAG_BITS) | {{(CMD_W-NUM_SRC){1'b0}}, flagQ};
  assign pulseMode = ctrlQ[BIT_PULSE];
  assign routeTodA = ctrlQ[BIT_ROUTE];
  assign xferEn    = ctrlQ[BIT_XFER];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcAct[i] = flagQ[i] & ~ctrlQ[MASK_BASE+i];
    assign srcOut[i] = ~ctrlQ[MASK_BASE+i] & (pulseMode ? pulseOn[i] : flagQ[i]);
  end

  always_comb begin
    if (routeTodA) begin
      intAEn = srcOut[SRC_TOD];
      intBEn = srcOut[SRC_WD];
    end else begin
      intAEn = srcOut[SRC_WD];
      intBEn = srcOut[SRC_TOD];
    end
    intALvl = 1'b0;
    intBLvl = ctrlQ[BIT_BPOL];
  end

  // R2: an alarm event always leaves its flag set
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFlag[SRC_TOD] |=> cmdQ[SRC_TOD]);
  // R3: a lone register access clears the watchdog flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrFlag[SRC_WD] && !stb.setFlag[SRC_WD]) |=> !cmdQ[SRC_WD]);
  // R4: host writes never disturb the flags
  p_wr_keeps_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCmd && stb.setFlag == '0 && stb.clrFlag == '0) |=> $stable(flagQ));
  // R5: both masks set leaves both outputs released
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[MASK_BASE] && ctrlQ[MASK_BASE+1]) |-> (!intAEn && !intBEn));
  // R10: level-mode time-of-day alarm reaches A when routed there
  p_route_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseMode && routeTodA && srcAct[SRC_TOD]) |-> intAEn);
  // R6: level-mode watchdog alarm reaches A when swapped
  p_level_swap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseMode && !routeTodA && srcAct[SRC_WD]) |-> intAEn);
endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_CYCLES = 600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic [7:0] cmdWrData,
  output logic [7:0] cmdRdData,
  input  logic       todMatch,
  input  logic       wdExpire,
  input  logic       todRegRd,
  input  logic       wdRegAcc,
  output logic       intAEn,
  output logic       intALvl,
  output logic       intBEn,
  output logic       intBLvl,
  output logic       xferEn
);
  strobe_t            stb;
  logic [NUM_SRC-1:0] srcAct;
  logic [NUM_SRC-1:0] pulseOn;

  alarm_irq_ctl #(.PULSE_CYCLES(PULSE_CYCLES)) i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrEn  (cmdWrEn),
    .todMatch (todMatch),
    .wdExpire (wdExpire),
    .todRegRd (todRegRd),
    .wdRegAcc (wdRegAcc),
    .srcAct   (srcAct),
    .stb      (stb),
    .pulseOn  (pulseOn)
  );

  alarm_irq_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (cmdWrData),
    .pulseOn (pulseOn),
    .cmdQ    (cmdRdData),
    .srcAct  (srcAct),
    .intAEn  (intAEn),
    .intALvl (intALvl),
    .intBEn  (intBEn),
    .intBLvl (intBLvl),
    .xferEn  (xferEn)
  );

  // R8: output A only ever pulls low
  p_a_sinks_r8: assert property (@(posedge clk) disable iff (!rstN)
    intAEn |-> !intALvl);
  // R9: B level tracks the stored polarity bit
  p_b_polarity_r9: assert property (@(posedge clk) disable iff (!rstN)
    intBLvl == cmdRdData[BIT_BPOL]);
endmodule

// File: tb/test_alarm_irq_router.sv
`timescale 1ns/1ps
module test_alarm_irq_router;
  localparam int PW = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWrEn = 1'b0;
  logic [7:0] cmdWrData = 8'h00;
  logic [7:0] cmdRdData;
  logic       todMatch = 1'b0, wdExpire = 1'b0, todRegRd = 1'b0, wdRegAcc = 1'b0;
  logic       intAEn, intALvl, intBEn, intBLvl, xferEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alarm_irq_router #(.PULSE_CYCLES(PW)) i_alarm_irq_router (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .todMatch(todMatch), .wdExpire(wdExpire),
    .todRegRd(todRegRd), .wdRegAcc(wdRegAcc), .intAEn(intAEn),
    .intALvl(intALvl), .intBEn(intBEn), .intBLvl(intBLvl), .xferEn(xferEn)
  );

  // Behavioural reference model
  int mFlag[2];
  int mCtrl;      // bits 7..2 of the command byte, stored as a full byte
  int mRem[2];
  int mPrev[2];

  function automatic int mMask(int s);
    return (mCtrl >> (2 + s)) & 1;
  endfunction

  function automatic int mSrc(int s);
    if (mMask(s) != 0) return 0;
    if (((mCtrl >> 4) & 1) != 0) return (mRem[s] > 0) ? 1 : 0;
    return mFlag[s];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFlag = '{0, 0};
      mCtrl = 8'h0C;
      mRem  = '{0, 0};
      mPrev = '{0, 0};
    end else begin
      if (todMatch) mFlag[0] = 1; else if (todRegRd) mFlag[0] = 0;
      if (wdExpire) mFlag[1] = 1; else if (wdRegAcc) mFlag[1] = 0;
      if (cmdWrEn) mCtrl = cmdWrData & 8'hFC;
      for (int s = 0; s < 2; s++) begin
        int act;
        act = (mFlag[s] != 0 && mMask(s) == 0) ? 1 : 0;
        if (act != 0 && mPrev[s] == 0) mRem[s] = PW;
        else if (mRem[s] > 0) mRem[s] = mRem[s] - 1;
        mPrev[s] = act;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      int route, expA, expB, expRd;
      route = (mCtrl >> 6) & 1;
      expA  = route ? mSrc(0) : mSrc(1);
      expB  = route ? mSrc(1) : mSrc(0);
      expRd = mCtrl | mFlag[0] | (mFlag[1] << 1);
      chk("R2 tod flag", int'(cmdRdData[0]), mFlag[0]);
      chk("R3 wd flag", int'(cmdRdData[1]), mFlag[1]);
      chk("R4 cmd byte", int'(cmdRdData), expRd);
      chk("R4 xferEn", int'(xferEn), (mCtrl >> 7) & 1);
      chk("R5/R6/R7/R10 output A", int'(intAEn), expA);
      chk("R5/R6/R7/R10 output B", int'(intBEn), expB);
      if (intAEn) chk("R8 A level", int'(intALvl), 0);
      chk("R9 B level", int'(intBLvl), (mCtrl >> 5) & 1);
    end
  end

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wrCmd(input logic [7:0] d);
    cmdWrEn = 1'b1; cmdWrData = d;
    cyc();
    cmdWrEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 reset byte", int'(cmdRdData), 8'h0C);
    chk("R1 A idle", int'(intAEn), 0);
    chk("R1 B idle", int'(intBEn), 0);

    // R2 set while masked: flag visible, nothing driven (R5)
    todMatch = 1'b1; cyc(); todMatch = 1'b0;
    chk("R2 flag set", int'(cmdRdData[0]), 1);
    chk("R5 masked A", int'(intAEn), 0);

    // R6/R10 level mode, tod on A, B sinks
    wrCmd(8'h40);
    chk("R10 tod on A", int'(intAEn), 1);
    chk("R8 A low", int'(intALvl), 0);
    wdExpire = 1'b1; cyc(); wdExpire = 1'b0;
    chk("R6 wd on B", int'(intBEn), 1);
    chk("R9 B sinks", int'(intBLvl), 0);
    wrCmd(8'h60);
    chk("R9 B sources", int'(intBLvl), 1);

    // R4 write with zero flag bits keeps flags
    wrCmd(8'h20);
    chk("R4 flags kept", int'(cmdRdData[1:0]), 3);
    chk("R10 swap still both on", int'(intAEn & intBEn), 1);

    // R5 mask only watchdog: A (wd) released, B (tod) stays
    wrCmd(8'h28);
    chk("R5 wd masked on A", int'(intAEn), 0);
    chk("R5 tod on B", int'(intBEn), 1);
    wrCmd(8'h20);

    // R2 clear, B releases in same cycle the flag reads 0 (R6)
    todRegRd = 1'b1; cyc(); todRegRd = 1'b0;
    chk("R2 cleared", int'(cmdRdData[0]), 0);
    chk("R6 B released", int'(intBEn), 0);

    // R3 set wins over clear, then clear alone
    wdExpire = 1'b1; wdRegAcc = 1'b1; cyc(); wdExpire = 1'b0; wdRegAcc = 1'b0;
    chk("R3 set wins", int'(cmdRdData[1]), 1);
    wdRegAcc = 1'b1; cyc(); wdRegAcc = 1'b0;
    chk("R3 cleared", int'(cmdRdData[1]), 0);
    // R2 same-cycle priority
    todMatch = 1'b1; todRegRd = 1'b1; cyc(); todMatch = 1'b0; todRegRd = 1'b0;
    chk("R2 set wins", int'(cmdRdData[0]), 1);
    todRegRd = 1'b1; cyc(); todRegRd = 1'b0;

    // R7 pulse mode, tod on A
    wrCmd(8'h50);
    todMatch = 1'b1; cyc(); todMatch = 1'b0;
    for (int i = 0; i < PW + 3; i++) begin
      chk("R7 pulse width", int'(intAEn), (i < PW) ? 1 : 0);
      cyc();
    end
    chk("R7 flag stays after pulse", int'(cmdRdData[0]), 1);
    // R7 retrigger after clear, swapped to B via route 0
    todRegRd = 1'b1; cyc(); todRegRd = 1'b0;
    wrCmd(8'h10);
    todMatch = 1'b1; cyc(); todMatch = 1'b0;
    chk("R7 pulse on B", int'(intBEn), 1);
    cyc(PW);
    chk("R7 pulse ended", int'(intBEn), 0);

    // R4 transfer enable with masks
    wrCmd(8'h8C);
    chk("R4 xferEn", int'(xferEn), 1);
    chk("R4 readback", int'(cmdRdData), 8'h8D);
    cyc(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule